// File: doc/BRIEF.md
# Nibble-Serial Parameter Loader

This block takes eight 8-bit configuration values for a spiking-neuron core over a narrow 4-bit data bus and presents them as one wide active parameter word. An external agent raises a load-mode level, then places each nibble on the data bus and pulses a load strobe. Each rising strobe edge captures one nibble into a shadow store. Every parameter travels as two nibbles, the more significant nibble first, and the eight parameters arrive in a fixed index order. No shadow value reaches the core until a footer nibble arrives.

After the sixteen data nibbles, one more strobe must carry the footer code 0xF. That footer copies all eight shadow values into the active registers on a single clock edge, so the core never sees a half-updated set. A wrong seventeenth nibble, or a drop of load mode partway through, abandons the sequence and leaves the active set untouched. The mode and strobe inputs may be asynchronous to the clock, so both pass through synchronizer flops before edge detection.

Top module: `nibble_param_loader`

## Requirements
- R1: After reset the active word holds the default codes, with parameter i in bits [8i+7:8i]: index 0 = 2, index 1 = 4, index 2 = 0, index 3 = 0, index 4 = 63, index 5 = 78, index 6 = 128, index 7 = 200 (0xC8).
- R2: Strobe edges that arrive while the synchronized load mode is low capture nothing and change neither the active word nor the nibble position.
- R3: Only a rising strobe edge captures a nibble. A strobe held high for many cycles captures exactly one nibble.
- R4: Nibbles 2i and 2i+1 of a sequence (counting from 0) form parameter i. Nibble 2i goes to bits [8i+7:8i+4] and nibble 2i+1 goes to bits [8i+3:8i].
- R5: A seventeenth nibble equal to 0xF copies all eight shadow values into the active word on one clock edge. The active word changes at no other time.
- R6: A seventeenth nibble other than 0xF leaves the active word unchanged and returns the nibble position to 0.
- R7: When the synchronized load mode goes low, the nibble position returns to 0. A partly sent sequence therefore never commits, and the next sequence starts at parameter 0.
- R8: The mode and strobe inputs each pass through two synchronizer flops. A committing footer strobe that rises before clock edge 1 changes the active word at edge 3 and not before. The data bus is sampled at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_mode_i | input | 1 | Load-mode level, may be asynchronous |
| load_strobe_i | input | 1 | Nibble strobe; its rising edge captures, may be asynchronous |
| nibble_i | input | NIB_W (4) | Nibble data bus |
| params_o | output | NUM_PARAMS*PARAM_W (64) | Active parameter word, parameter i in bits [8i+7:8i] |

## Verification
The assertions assume that the nibble bus is stable from the strobe's rising edge until at least three clocks later, since the bus is sampled without a synchronizer. They also assume that strobe pulses and gaps each last at least one clock, so the edge detector sees every edge. The stimulus changes data only on the falling clock edge where the strobe rises. It then holds the strobe high for at least five clocks and low for five more. The stimulus lets load mode settle for four clocks before and after each change.

// File: rtl/nibble_loader_pkg.sv
package nibble_loader_pkg;
   localparam int unsigned PL_NUM_PARAMS = 8;
   localparam int unsigned PL_PARAM_W    = 8;
   localparam int unsigned PL_NIB_W      = 4;

   // Reset codes, index 7 in the top byte down to index 0 in the bottom byte.
   localparam logic [PL_NUM_PARAMS*PL_PARAM_W-1:0] PL_RESET_VEC = {
      8'd200,   // 7 capacitance
      8'd128,   // 6 bias current, zero-value code
      8'd78,    // 5 threshold
      8'd63,    // 4 reset potential
      8'd0,     // 3 spike increment
      8'd0,     // 2 subthreshold coupling
      8'd4,     // 1 adaptation time constant
      8'd2      // 0 slope factor
   };
endpackage

// File: rtl/loader_sync.sv
module loader_sync #(
   parameter int unsigned WIDTH  = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("loader_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] stage_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q <= '0;
      else        stage_q <= {stage_q[STAGES-2:0], d_i};
   end

   assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/loader_edge.sv
module loader_edge #(
   parameter int unsigned WIDTH = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] level_i,
   output logic [WIDTH-1:0] rise_o
);
   logic [WIDTH-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= level_i;
   end

   assign rise_o = level_i & ~prev_q;
endmodule

// File: rtl/loader_sequencer.sv
module loader_sequencer #(
   parameter int unsigned NIB_W      = 4,
   parameter int unsigned PARAM_W    = 8,
   parameter int unsigned NUM_PARAMS = 8,
   parameter logic [NIB_W-1:0] FOOTER = {NIB_W{1'b1}}
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          mode_i,
   input  logic                          take_i,
   input  logic [NIB_W-1:0]              nibble_i,
   output logic [NUM_PARAMS*PARAM_W-1:0] shadow_o,
   output logic                          commit_o
);
   localparam int unsigned NPP   = PARAM_W / NIB_W;
   localparam int unsigned TOTAL = NUM_PARAMS * NPP;
   localparam int unsigned CW    = $clog2(TOTAL + 1);
   localparam logic [CW-1:0] LAST = CW'(TOTAL);

   logic [CW-1:0]    cnt_q;
   logic             accept;
   logic             at_footer;
   logic [NIB_W-1:0] slot_q [TOTAL];

   assign accept    = take_i && mode_i;
   assign at_footer = (cnt_q == LAST);
   assign commit_o  = accept && at_footer && (nibble_i == FOOTER);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt_q <= '0;
      else if (!mode_i)           cnt_q <= '0;
      else if (accept) begin
         if (at_footer)           cnt_q <= '0;
         else                     cnt_q <= cnt_q + 1'b1;
      end
   end

   // One storage slot per nibble position; higher nibble of each parameter first.
   generate
      for (genvar k = 0; k < TOTAL; k++) begin : g_slot
         localparam int unsigned PIDX = k / NPP;
         localparam int unsigned JIDX = k % NPP;
         localparam int unsigned OFF  = PIDX * PARAM_W + (NPP - 1 - JIDX) * NIB_W;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                               slot_q[k] <= '0;
            else if (accept && cnt_q == CW'(k))       slot_q[k] <= nibble_i;
         end

         assign shadow_o[OFF +: NIB_W] = slot_q[k];
      end
   endgenerate

   a_r7_mode_low_clears: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_i |=> (cnt_q == '0));

   a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);

   a_r3_idle_count_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i && !take_i) |=> $stable(cnt_q));

   a_r6_wrap_after_footer_slot: assert property (@(posedge clk) disable iff (!rst_n)
      (take_i && mode_i && cnt_q == LAST) |=> (cnt_q == '0));
endmodule

// File: rtl/loader_bank.sv
module loader_bank #(
   parameter int unsigned PARAM_W    = 8,
   parameter int unsigned NUM_PARAMS = 8,
   parameter logic [NUM_PARAMS*PARAM_W-1:0] RESET_VEC = '0
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          commit_i,
   input  logic [NUM_PARAMS*PARAM_W-1:0] shadow_i,
   output logic [NUM_PARAMS*PARAM_W-1:0] params_o
);
   logic [PARAM_W-1:0] reg_q [NUM_PARAMS];

   generate
      for (genvar i = 0; i < NUM_PARAMS; i++) begin : g_param
         localparam logic [PARAM_W-1:0] DEF = RESET_VEC[i*PARAM_W +: PARAM_W];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        reg_q[i] <= DEF;
            else if (commit_i) reg_q[i] <= shadow_i[i*PARAM_W +: PARAM_W];
         end

         assign params_o[i*PARAM_W +: PARAM_W] = reg_q[i];
      end
   endgenerate

   a_r5_hold_without_commit: assert property (@(posedge clk) disable iff (!rst_n)
      !commit_i |=> $stable(params_o));

   a_r5_commit_loads_all: assert property (@(posedge clk) disable iff (!rst_n)
      commit_i |=> (params_o == $past(shadow_i)));
endmodule

// File: rtl/nibble_param_loader.sv
module nibble_param_loader
   import nibble_loader_pkg::*;
#(
   parameter int unsigned NIB_W       = PL_NIB_W,
   parameter int unsigned PARAM_W     = PL_PARAM_W,
   parameter int unsigned NUM_PARAMS  = PL_NUM_PARAMS,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [NIB_W-1:0] FOOTER = {NIB_W{1'b1}},
   parameter logic [NUM_PARAMS*PARAM_W-1:0] RESET_VEC = PL_RESET_VEC
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          load_mode_i,
   input  logic                          load_strobe_i,
   input  logic [NIB_W-1:0]              nibble_i,
   output logic [NUM_PARAMS*PARAM_W-1:0] params_o
);
   generate
      if (PARAM_W % NIB_W != 0) begin : g_bad_split
         $error("nibble_param_loader: PARAM_W must be a multiple of NIB_W");
      end
      if (NUM_PARAMS < 1) begin : g_bad_count
         $error("nibble_param_loader: NUM_PARAMS must be at least 1");
      end
   endgenerate

   logic [1:0]                    ctl_sync;
   logic                          mode_s;
   logic                          strobe_s;
   logic [0:0]                    take;
   logic                          commit;
   logic [NUM_PARAMS*PARAM_W-1:0] shadow;

   loader_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({load_mode_i, load_strobe_i}),
      .q_o   (ctl_sync)
   );

   assign mode_s   = ctl_sync[1];
   assign strobe_s = ctl_sync[0];

   loader_edge #(.WIDTH(1)) u_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .level_i (strobe_s),
      .rise_o  (take)
   );

   loader_sequencer #(
      .NIB_W(NIB_W), .PARAM_W(PARAM_W), .NUM_PARAMS(NUM_PARAMS), .FOOTER(FOOTER)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode_i   (mode_s),
      .take_i   (take[0]),
      .nibble_i (nibble_i),
      .shadow_o (shadow),
      .commit_o (commit)
   );

   loader_bank #(
      .PARAM_W(PARAM_W), .NUM_PARAMS(NUM_PARAMS), .RESET_VEC(RESET_VEC)
   ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .commit_i (commit),
      .shadow_i (shadow),
      .params_o (params_o)
   );

   a_r2_commit_needs_mode: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> mode_s);

   a_r3_no_back_to_back_take: assert property (@(posedge clk) disable iff (!rst_n)
      take[0] |=> !take[0]);
endmodule

// File: tb/tb_nibble_param_loader.sv
module tb_nibble_param_loader;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        mode;
   logic        strobe;
   logic [3:0]  nib;
   logic [63:0] params;

   always #2 clk = ~clk;

   nibble_param_loader dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .load_mode_i   (mode),
      .load_strobe_i (strobe),
      .nibble_i      (nib),
      .params_o      (params)
   );

   localparam logic [63:0] DEF = {8'd200, 8'd128, 8'd78, 8'd63, 8'd0, 8'd0, 8'd4, 8'd2};

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   // Behavioural reference: input history, position counter, shadow and active bytes.
   int         h_mode [0:2];
   int         h_str  [0:2];
   int         m_cnt;
   logic [7:0] m_sh  [0:7];
   logic [7:0] m_act [0:7];

   function automatic logic [63:0] model_word();
      logic [63:0] w;
      for (int i = 0; i < 8; i++) w[i*8 +: 8] = m_act[i];
      return w;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < 3; i++) begin h_mode[i] = 0; h_str[i] = 0; end
         m_cnt = 0;
         for (int i = 0; i < 8; i++) begin
            m_sh[i]  = 8'h00;
            m_act[i] = DEF[i*8 +: 8];
         end
      end else begin
         int mode_v;
         int ev;
         mode_v = h_mode[1];
         ev     = (h_str[1] != 0 && h_str[2] == 0) ? 1 : 0;
         if (mode_v == 0) m_cnt = 0;
         else if (ev != 0) begin
            if (m_cnt == 16) begin
               if (nib == 4'hF) for (int i = 0; i < 8; i++) m_act[i] = m_sh[i];
               m_cnt = 0;
            end else begin
               if (m_cnt % 2 == 0) m_sh[m_cnt/2][7:4] = nib;
               else                m_sh[m_cnt/2][3:0] = nib;
               m_cnt++;
            end
         end
         h_mode[2] = h_mode[1]; h_mode[1] = h_mode[0]; h_mode[0] = int'(mode);
         h_str[2]  = h_str[1];  h_str[1]  = h_str[0];  h_str[0]  = int'(strobe);
      end
   end

   task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, got, exp, $time);
      end
   endtask

   // Every-cycle comparison against the model (R8 timing, all behaviour).
   always @(negedge clk) begin
      if (rst_n && !done) chk("R8 model", params, model_word());
   end

   task automatic send_nib(input logic [3:0] v, input int hold);
      @(negedge clk);
      nib    = v;
      strobe = 1'b1;
      repeat (hold) @(negedge clk);
      strobe = 1'b0;
      repeat (5) @(negedge clk);
   endtask

   task automatic send_data(input logic [63:0] v, input int count, input int hold);
      for (int k = 0; k < count; k++) begin
         if (k % 2 == 0) send_nib(v[(k/2)*8 + 4 +: 4], hold);
         else            send_nib(v[(k/2)*8 +: 4], hold);
      end
   endtask

   task automatic set_mode(input logic v);
      @(negedge clk);
      mode = v;
      repeat (4) @(negedge clk);
   endtask

   localparam logic [63:0] SET_A = 64'hC8B24E3F28029A17;
   localparam logic [63:0] SET_B = 64'hC8994E4E00040A55;
   localparam logic [63:0] SET_C = 64'h01D03F3F00007E81;
   localparam logic [63:0] SET_D = 64'h5A6B7C8D9EAFB0C1;
   localparam logic [63:0] SET_E = 64'hF0E1D2C3B4A59687;

   initial begin
      rst_n = 1'b0; mode = 1'b0; strobe = 1'b0; nib = 4'h0;
      repeat (10) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1 reset defaults", params, DEF);

      // R2: strobes with load mode low are ignored.
      for (int k = 0; k < 17; k++) send_nib(4'hF, 5);
      chk("R2 strobes ignored with mode low", params, DEF);

      // R4/R5: full load, byte packing and commit.
      set_mode(1'b1);
      send_data(SET_A, 16, 5);
      chk("R5 no change before footer", params, DEF);
      send_nib(4'hF, 5);
      chk("R4 packing of set A", params, SET_A);
      chk("R4 index 7 byte", {56'd0, params[63:56]}, 64'hC8);

      // R8/R5: footer latency and single-edge commit.
      send_data(SET_B, 16, 5);
      @(negedge clk);
      nib = 4'hF; strobe = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk("R8 old value after second edge", params, SET_A);
      @(negedge clk);
      chk("R5 whole set after third edge", params, SET_B);
      repeat (3) @(negedge clk);
      strobe = 1'b0;
      repeat (5) @(negedge clk);

      // R6: wrong footer discards, then a fresh sequence lands.
      send_data(SET_C, 16, 5);
      send_nib(4'h3, 5);
      chk("R6 bad footer keeps active", params, SET_B);
      send_data(SET_C, 16, 5);
      send_nib(4'hF, 5);
      chk("R6 restart after bad footer", params, SET_C);

      // R7: mode drop abandons a partial sequence.
      send_data(SET_D, 10, 5);
      set_mode(1'b0);
      set_mode(1'b1);
      send_data(SET_D, 6, 5);
      send_nib(4'hF, 5);
      chk("R7 partial sequence never commits", params, SET_C);
      set_mode(1'b0);
      set_mode(1'b1);
      send_data(SET_D, 16, 5);
      send_nib(4'hF, 5);
      chk("R7 clean load after mode drop", params, SET_D);

      // R3: long-held strobe captures once per rising edge.
      send_data(SET_E, 16, 30);
      send_nib(4'hF, 30);
      chk("R3 held strobe single capture", params, SET_E);

      // R2: strobes while mode is low do not disturb a following load.
      set_mode(1'b0);
      for (int k = 0; k < 3; k++) send_nib(4'h5, 5);
      chk("R2 no effect with mode low", params, SET_E);
      set_mode(1'b1);
      send_data(SET_A, 16, 5);
      send_nib(4'hF, 5);
      chk("R2 aligned load after ignored strobes", params, SET_A);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(4 * 150000);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL R8 watchdog actual=timeout expected=completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule